// File: doc/BRIEF.md
# Stack-Pop Cracking Fetch and Single-Port Write-Back

This block lets a small pipelined processor run with a register file that has only one write port. Most instructions write at most one register. A stack pop is the exception: it needs both the stack-pointer update and the loaded value written at once. The block removes that need by splitting every pop into two passes through the pipeline.

On the first fetch of a pop, the block forwards the pop opcode to decode and predicts the same PC again. Decode treats that first pass as an add of one word (8 bytes) to the stack pointer. The refetch of the same address is then tagged with a dedicated second-half opcode. Decode treats it as a load into the named register from one word below the new stack pointer. Because the increment is done before the load, a pop into the stack pointer ends with the loaded value in it.

At write-back, a priority multiplexer folds the memory-result destination and the ALU-result destination onto the one physical port. The second port is tied off. Stall and flush come from hazard logic outside the block. The ALU, the memory stage and the rest of the decoder also sit outside the block.

Top module: `pop_split_core`

## Requirements
- R1: The merged write-port register ID equals the memory-result destination when that destination is not 4'hF ("no register"). Otherwise it equals the ALU-result destination.
- R2: The merged write-port value follows the same choice: the memory-result value when the memory destination is not 4'hF, otherwise the ALU-result value.
- R3: The second write port always presents register ID 4'hF and value zero.
- R4: A pop opcode (4'hB) in decode is issued as the add-immediate opcode 4'hC. Its ALU destination is register 4 (the stack pointer), its source is register 4, its immediate is +8, and its memory destination is 4'hF.
- R5: When a pop (4'hB) is fetched with no second half pending, the opcode sent to decode is 4'hB and the predicted next PC equals the current PC.
- R6: The fetch that follows an accepted first pass sends opcode 4'hE to decode and predicts the fall-through PC. The second half is issued only once.
- R7: Opcode 4'hE in decode is issued as a load. Its memory destination is the rA field, its source is register 4, its immediate is -8, and its ALU destination is 4'hF.
- R8: Popping into register 4 leaves register 4 holding the word that was stored at the old stack pointer.
- R9: A fetch stall holds a pending second half, so opcode 4'hE is still issued once the stall lifts.
- R10: A flush drops a pending second half, so the next pop fetched is sent as 4'hB again.
- R11: Any other opcode passes to decode unchanged, with the fall-through PC predicted. In decode it yields no destinations (4'hF), no source and a zero immediate.
- R12: Two pops back to back load consecutive stack words into their registers and advance the stack pointer by 16 in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_opcode | input | 4 | Opcode of the instruction being fetched |
| f_pc | input | PCW | Address of the instruction being fetched |
| f_pc_fall | input | PCW | Address of the next sequential instruction |
| f_stall | input | 1 | Fetch/decode stall: decode register holds |
| f_flush | input | 1 | Flush: a bubble enters decode |
| d_opcode | output | 4 | Opcode to load into the decode register |
| pred_pc | output | PCW | Predicted next fetch address |
| d_icode | input | 4 | Opcode held in the decode register |
| d_ra | input | 4 | rA field held in the decode register |
| x_op | output | 4 | Operation issued to execute |
| x_dst_alu | output | 4 | ALU-result destination register |
| x_dst_mem | output | 4 | Memory-result destination register |
| x_src | output | 4 | Base/source register read |
| x_imm | output | DW | Immediate or offset |
| w_dst_alu | input | 4 | Write-back ALU-result destination |
| w_val_alu | input | DW | Write-back ALU-result value |
| w_dst_mem | input | 4 | Write-back memory-result destination |
| w_val_mem | input | DW | Write-back memory-result value |
| rf_e_id | output | 4 | Register ID on the single active write port |
| rf_e_val | output | DW | Value on the single active write port |
| rf_m_id | output | 4 | Register ID on the tied-off port |
| rf_m_val | output | DW | Value on the tied-off port |

## Verification
The bench targets a pop into the stack pointer. If the design loaded before it incremented, or gave the ALU result priority at write-back, the stack pointer would end at the incremented address instead of the loaded word. Back-to-back pops test that the pending flag clears after exactly one second half. A design that failed to clear it would send 4'hE for the second pop's first fetch and lose a stack increment. The bench also stalls and flushes while a second half is pending. A design that dropped the flag on a stall would never perform the load. A design that kept the flag through a flush would turn the next fresh pop into a bare load.

// File: rtl/pop_split_pkg.sv
package pop_split_pkg;
  localparam int OPW  = 4;
  localparam int REGW = 4;

  typedef logic [OPW-1:0]  opcode_t;
  typedef logic [REGW-1:0] reg_id_t;

  localparam opcode_t OP_POP   = 4'hB;
  localparam opcode_t OP_IADD  = 4'hC;
  localparam opcode_t OP_POP2  = 4'hE;

  localparam reg_id_t REG_SP   = 4'h4;
  localparam reg_id_t REG_NONE = 4'hF;
endpackage

// File: rtl/ps_rst_sync.sv
module ps_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/ps_fetch_crack.sv
module ps_fetch_crack
  import pop_split_pkg::*;
#(
  parameter int PCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  opcode_t        f_opcode,
  input  logic [PCW-1:0] f_pc,
  input  logic [PCW-1:0] f_pc_fall,
  input  logic           f_stall,
  input  logic           f_flush,
  output opcode_t        d_opcode,
  output logic [PCW-1:0] pred_pc
);
  logic half_pend_q;
  logic half_pend_d;
  logic half_pend_en;
  logic accept;

  // decode register accepts the fetched opcode this cycle
  assign accept = !f_stall && !f_flush;

  // next-state for the second-half pending flag
  always_comb begin
    half_pend_d  = half_pend_q;
    half_pend_en = 1'b0;
    if (f_flush) begin
      half_pend_d  = 1'b0;
      half_pend_en = 1'b1;
    end else if (accept) begin
      half_pend_en = 1'b1;
      if (half_pend_q) half_pend_d = 1'b0;
      else             half_pend_d = (f_opcode == OP_POP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            half_pend_q <= 1'b0;
    else if (half_pend_en) half_pend_q <= half_pend_d;
  end

  // opcode substitution and next-PC prediction
  always_comb begin
    d_opcode = f_opcode;
    pred_pc  = f_pc_fall;
    if (half_pend_q) begin
      d_opcode = OP_POP2;
      pred_pc  = f_pc_fall;
    end else if (f_opcode == OP_POP) begin
      d_opcode = OP_POP;
      pred_pc  = f_pc;
    end
  end
endmodule

// File: rtl/ps_decode_crack.sv
module ps_decode_crack
  import pop_split_pkg::*;
#(
  parameter int DW         = 64,
  parameter int WORD_BYTES = 8
) (
  input  opcode_t         d_icode,
  input  reg_id_t         d_ra,
  output opcode_t         x_op,
  output reg_id_t         x_dst_alu,
  output reg_id_t         x_dst_mem,
  output reg_id_t         x_src,
  output logic [DW-1:0]   x_imm
);
  localparam logic [DW-1:0] STEP_UP   = DW'(WORD_BYTES);
  localparam logic [DW-1:0] STEP_DOWN = '0 - STEP_UP;

  always_comb begin
    x_op      = d_icode;
    x_dst_alu = REG_NONE;
    x_dst_mem = REG_NONE;
    x_src     = REG_NONE;
    x_imm     = '0;
    unique case (d_icode)
      OP_POP: begin
        // first pass: bump the stack pointer by one word
        x_op      = OP_IADD;
        x_dst_alu = REG_SP;
        x_src     = REG_SP;
        x_imm     = STEP_UP;
      end
      OP_POP2: begin
        // second pass: load from one word below the bumped pointer
        x_op      = OP_POP2;
        x_dst_mem = d_ra;
        x_src     = REG_SP;
        x_imm     = STEP_DOWN;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ps_wb_merge.sv
module ps_wb_merge
  import pop_split_pkg::*;
#(
  parameter int DW = 64
) (
  input  reg_id_t       w_dst_alu,
  input  logic [DW-1:0] w_val_alu,
  input  reg_id_t       w_dst_mem,
  input  logic [DW-1:0] w_val_mem,
  output reg_id_t       rf_e_id,
  output logic [DW-1:0] rf_e_val,
  output reg_id_t       rf_m_id,
  output logic [DW-1:0] rf_m_val
);
  logic mem_sel;

  assign mem_sel = (w_dst_mem != REG_NONE);

  always_comb begin
    if (mem_sel) begin
      rf_e_id  = w_dst_mem;
      rf_e_val = w_val_mem;
    end else begin
      rf_e_id  = w_dst_alu;
      rf_e_val = w_val_alu;
    end
  end

  // second port is tied off
  assign rf_m_id  = REG_NONE;
  assign rf_m_val = '0;
endmodule

// File: rtl/pop_split_core.sv
module pop_split_core
  import pop_split_pkg::*;
#(
  parameter int PCW        = 16,
  parameter int DW         = 64,
  parameter int WORD_BYTES = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     f_opcode,
  input  logic [PCW-1:0] f_pc,
  input  logic [PCW-1:0] f_pc_fall,
  input  logic           f_stall,
  input  logic           f_flush,
  output logic [3:0]     d_opcode,
  output logic [PCW-1:0] pred_pc,
  input  logic [3:0]     d_icode,
  input  logic [3:0]     d_ra,
  output logic [3:0]     x_op,
  output logic [3:0]     x_dst_alu,
  output logic [3:0]     x_dst_mem,
  output logic [3:0]     x_src,
  output logic [DW-1:0]  x_imm,
  input  logic [3:0]     w_dst_alu,
  input  logic [DW-1:0]  w_val_alu,
  input  logic [3:0]     w_dst_mem,
  input  logic [DW-1:0]  w_val_mem,
  output logic [3:0]     rf_e_id,
  output logic [DW-1:0]  rf_e_val,
  output logic [3:0]     rf_m_id,
  output logic [DW-1:0]  rf_m_val
);
  logic rst_n_s;

  ps_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  ps_fetch_crack #(.PCW(PCW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .f_opcode  (f_opcode),
    .f_pc      (f_pc),
    .f_pc_fall (f_pc_fall),
    .f_stall   (f_stall),
    .f_flush   (f_flush),
    .d_opcode  (d_opcode),
    .pred_pc   (pred_pc)
  );

  ps_decode_crack #(.DW(DW), .WORD_BYTES(WORD_BYTES)) u_decode (
    .d_icode   (d_icode),
    .d_ra      (d_ra),
    .x_op      (x_op),
    .x_dst_alu (x_dst_alu),
    .x_dst_mem (x_dst_mem),
    .x_src     (x_src),
    .x_imm     (x_imm)
  );

  ps_wb_merge #(.DW(DW)) u_wb (
    .w_dst_alu (w_dst_alu),
    .w_val_alu (w_val_alu),
    .w_dst_mem (w_dst_mem),
    .w_val_mem (w_val_mem),
    .rf_e_id   (rf_e_id),
    .rf_e_val  (rf_e_val),
    .rf_m_id   (rf_m_id),
    .rf_m_val  (rf_m_val)
  );

  logic taken;
  assign taken = !f_stall && !f_flush;

  // R5: an accepted first pass is followed by the second-half opcode
  assert_refetch_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (d_opcode == OP_POP && pred_pc == f_pc && taken) |=> (d_opcode == OP_POP2));

  // R6: second half resumes sequential fetch
  assert_pop2_fall_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (d_opcode == OP_POP2) |-> (pred_pc == f_pc_fall));

  // R6: second half is issued once
  assert_pop2_once_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (d_opcode == OP_POP2 && taken) |=> (d_opcode != OP_POP2));

  // R9: stall keeps the pending second half
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (d_opcode == OP_POP2 && f_stall && !f_flush) |=> (d_opcode == OP_POP2));

  // R10: flush drops any pending second half
  assert_flush_clear_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    f_flush |=> (d_opcode != OP_POP2));

  // R1: memory destination takes the port when valid
  assert_mem_first_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (w_dst_mem != REG_NONE) |-> (rf_e_id == w_dst_mem && rf_e_val == w_val_mem));

  // R2: ALU result used otherwise
  assert_alu_fallback_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (w_dst_mem == REG_NONE) |-> (rf_e_id == w_dst_alu && rf_e_val == w_val_alu));

  // R4: first pass targets the stack pointer only
  assert_first_half_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (d_icode == OP_POP) |-> (x_dst_alu == REG_SP && x_dst_mem == REG_NONE && x_op == OP_IADD));

  // R7: second half targets rA through memory only
  assert_second_half_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (d_icode == OP_POP2) |-> (x_dst_mem == d_ra && x_dst_alu == REG_NONE && x_src == REG_SP));
endmodule

// File: tb/pop_split_core_bench.sv
module pop_split_core_bench;
  localparam int PCW = 16;
  localparam int DW  = 64;
  localparam logic [3:0] C_POP = 4'hB, C_ADD = 4'hC, C_LD = 4'hE;
  localparam logic [3:0] C_SP = 4'h4, C_NO = 4'hF;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n;
  logic [3:0]     f_opcode;
  logic [PCW-1:0] f_pc, f_pc_fall;
  logic           f_stall, f_flush;
  logic [3:0]     d_opcode;
  logic [PCW-1:0] pred_pc;
  logic [3:0]     d_icode, d_ra;
  logic [3:0]     x_op, x_dst_alu, x_dst_mem, x_src;
  logic [DW-1:0]  x_imm;
  logic [3:0]     w_dst_alu, w_dst_mem;
  logic [DW-1:0]  w_val_alu, w_val_mem;
  logic [3:0]     rf_e_id, rf_m_id;
  logic [DW-1:0]  rf_e_val, rf_m_val;

  pop_split_core u_pop_split_core (
    .clk(clk), .rst_n(rst_n), .f_opcode(f_opcode), .f_pc(f_pc), .f_pc_fall(f_pc_fall),
    .f_stall(f_stall), .f_flush(f_flush), .d_opcode(d_opcode), .pred_pc(pred_pc),
    .d_icode(d_icode), .d_ra(d_ra), .x_op(x_op), .x_dst_alu(x_dst_alu),
    .x_dst_mem(x_dst_mem), .x_src(x_src), .x_imm(x_imm), .w_dst_alu(w_dst_alu),
    .w_val_alu(w_val_alu), .w_dst_mem(w_dst_mem), .w_val_mem(w_val_mem),
    .rf_e_id(rf_e_id), .rf_e_val(rf_e_val), .rf_m_id(rf_m_id), .rf_m_val(rf_m_val)
  );

  int n_chk = 0;
  int n_bad = 0;

  // model state
  logic [DW-1:0]  rf [16];
  logic [3:0]     im_op [32];
  logic [3:0]     im_ra [32];
  logic [PCW-1:0] pc;
  logic [3:0]     dq_op, dq_ra;
  logic [3:0]     wq_da, wq_dm;
  logic [DW-1:0]  wq_va, wq_vm;
  bit             pend;

  function automatic logic [DW-1:0] memword(input logic [DW-1:0] a);
    return 64'h0000_A000 + a;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_prog_clear();
    for (int i = 0; i < 32; i++) begin
      im_op[i] = 4'h0;
      im_ra[i] = C_NO;
    end
    for (int i = 0; i < 16; i++) rf[i] = 64'(i) * 64'h11;
    pc = '0; dq_op = 4'h0; dq_ra = C_NO;
    wq_da = C_NO; wq_dm = C_NO; wq_va = '0; wq_vm = '0;
  endtask

  // one clock: drive, sample at negedge, advance the model
  task automatic cycle(input bit stall, input bit flush, input logic [PCW-1:0] redir);
    logic [3:0]     e_op, e_id;
    logic [PCW-1:0] e_pred;
    logic [DW-1:0]  e_val, base;
    string          rq;
    f_opcode = im_op[pc[4:0]]; f_pc = pc; f_pc_fall = pc + 1'b1;
    f_stall = stall; f_flush = flush;
    d_icode = dq_op; d_ra = dq_ra;
    w_dst_alu = wq_da; w_val_alu = wq_va; w_dst_mem = wq_dm; w_val_mem = wq_vm;
    @(negedge clk);
    // fetch side
    if (pend) begin
      e_op = C_LD; e_pred = pc + 1'b1; rq = "R6";
    end else if (im_op[pc[4:0]] == C_POP) begin
      e_op = C_POP; e_pred = pc; rq = "R5";
    end else begin
      e_op = im_op[pc[4:0]]; e_pred = pc + 1'b1; rq = "R11";
    end
    check(rq, "d_opcode", 64'(d_opcode), 64'(e_op));
    check(rq, "pred_pc", 64'(pred_pc), 64'(e_pred));
    // write-back side
    e_id  = (wq_dm != C_NO) ? wq_dm : wq_da;
    e_val = (wq_dm != C_NO) ? wq_vm : wq_va;
    check("R1", "rf_e_id", 64'(rf_e_id), 64'(e_id));
    check("R2", "rf_e_val", rf_e_val, e_val);
    check("R3", "rf_m_id", 64'(rf_m_id), 64'(C_NO));
    check("R3", "rf_m_val", rf_m_val, 64'd0);
    if (e_id != C_NO) rf[e_id] = e_val;
    // decode hints and execute
    wq_da = C_NO; wq_dm = C_NO; wq_va = '0; wq_vm = '0;
    if (dq_op == C_POP) begin
      check("R4", "x_op", 64'(x_op), 64'(C_ADD));
      check("R4", "x_dst_alu", 64'(x_dst_alu), 64'(C_SP));
      check("R4", "x_dst_mem", 64'(x_dst_mem), 64'(C_NO));
      check("R4", "x_src", 64'(x_src), 64'(C_SP));
      check("R4", "x_imm", x_imm, 64'd8);
      if (!stall) begin wq_da = C_SP; wq_va = rf[C_SP] + 64'd8; end
    end else if (dq_op == C_LD) begin
      check("R7", "x_op", 64'(x_op), 64'(C_LD));
      check("R7", "x_dst_mem", 64'(x_dst_mem), 64'(dq_ra));
      check("R7", "x_dst_alu", 64'(x_dst_alu), 64'(C_NO));
      check("R7", "x_src", 64'(x_src), 64'(C_SP));
      check("R7", "x_imm", x_imm, -64'sd8);
      base = rf[C_SP] - 64'd8;
      if (!stall) begin wq_dm = dq_ra; wq_vm = memword(base); end
    end else begin
      check("R11", "x_op", 64'(x_op), 64'(dq_op));
      check("R11", "x_dst_alu", 64'(x_dst_alu), 64'(C_NO));
      check("R11", "x_dst_mem", 64'(x_dst_mem), 64'(C_NO));
      check("R11", "x_imm", x_imm, 64'd0);
    end
    // advance fetch/decode
    if (flush) begin
      dq_op = 4'h0; dq_ra = C_NO; pc = redir; pend = 1'b0;
    end else if (!stall) begin
      dq_op = e_op; dq_ra = im_ra[pc[4:0]]; pc = e_pred;
      pend = (!pend && e_op == C_POP);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic run_idle(input int n);
    for (int k = 0; k < n; k++) cycle(1'b0, 1'b0, '0);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  logic [DW-1:0] sp0;

  initial begin
    pend = 1'b0;
    load_prog_clear();
    rst_n = 1'b0;
    f_opcode = C_POP; f_pc = 16'h0005; f_pc_fall = 16'h0006;
    f_stall = 1'b0; f_flush = 1'b0;
    d_icode = 4'h0; d_ra = C_NO;
    w_dst_alu = C_NO; w_val_alu = '0; w_dst_mem = C_NO; w_val_mem = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: nothing pending, pop takes the first-pass path
    check("R5", "reset d_opcode", 64'(d_opcode), 64'(C_POP));
    check("R5", "reset pred_pc", 64'(pred_pc), 64'h5);
    check("R3", "reset rf_m_id", 64'(rf_m_id), 64'(C_NO));
    rst_n = 1'b1;
    f_opcode = 4'h0;
    repeat (4) @(posedge clk);
    #1;

    // pop into a general register
    load_prog_clear();
    sp0 = 64'd100; rf[C_SP] = sp0;
    im_op[0] = C_POP; im_ra[0] = 4'h2;
    run_idle(8);
    check("R12", "pop r2 value", rf[2], memword(sp0));
    check("R12", "pop r2 sp", rf[C_SP], sp0 + 64'd8);

    // pop into the stack pointer
    load_prog_clear();
    sp0 = 64'd200; rf[C_SP] = sp0;
    im_op[0] = C_POP; im_ra[0] = C_SP;
    run_idle(8);
    check("R8", "pop sp value", rf[C_SP], memword(sp0));

    // back-to-back pops plus a pass-through opcode
    load_prog_clear();
    sp0 = 64'd300; rf[C_SP] = sp0;
    im_op[0] = C_POP; im_ra[0] = 4'h1;
    im_op[1] = C_POP; im_ra[1] = 4'h3;
    im_op[2] = 4'h3;  im_ra[2] = 4'h7;
    run_idle(10);
    check("R12", "b2b r1", rf[1], memword(sp0));
    check("R12", "b2b r3", rf[3], memword(sp0 + 64'd8));
    check("R12", "b2b sp", rf[C_SP], sp0 + 64'd16);
    check("R11", "b2b r7 untouched", rf[7], 64'h77);

    // stall while the second half is pending
    load_prog_clear();
    sp0 = 64'd400; rf[C_SP] = sp0;
    im_op[0] = C_POP; im_ra[0] = 4'h5;
    cycle(1'b0, 1'b0, '0);
    cycle(1'b1, 1'b0, '0);
    cycle(1'b1, 1'b0, '0);
    run_idle(6);
    check("R9", "stall r5", rf[5], memword(sp0));
    check("R9", "stall sp", rf[C_SP], sp0 + 64'd8);

    // flush while the second half is pending, then a fresh pop
    load_prog_clear();
    sp0 = 64'd500; rf[C_SP] = sp0;
    im_op[0] = C_POP;  im_ra[0] = 4'h6;
    im_op[10] = C_POP; im_ra[10] = 4'h9;
    cycle(1'b0, 1'b0, '0);
    cycle(1'b0, 1'b1, 16'd10);
    run_idle(8);
    check("R10", "flush r6 untouched", rf[6], 64'h66);
    check("R10", "flush r9", rf[9], memword(sp0 + 64'd8));
    check("R10", "flush sp", rf[C_SP], sp0 + 64'd16);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule